// File: doc/BRIEF.md
# Codec Power-State Sequencer

This block sits between a system power manager and the control-bus writer of a stereo audio codec. The manager asks for one of four power goals: fully active, standby, full power-down, or a noise-recovery cycle that is needed after the codec's master clock was stopped and restarted. The block expands each goal into a fixed, pop-free series of codec register writes. Each write is a 7-bit register address and a 9-bit value, passed out through a valid/ready handshake.

The block keeps its own copies of the three codec registers it changes: the power register at address 0x06, the digital-path register at 0x05 (soft-mute is bit 3) and the analog-path register at 0x04 (DAC select is bit 4). Every write is built from these copies, so bits the sequence does not own are written back unchanged. In the power register a 1 switches a section off. The bit positions are 0 line input, 3 DAC, 4 outputs, 5 oscillator, 6 clock output and 7 whole device.

After any write that powers the device back up, the block holds off for a settling time of `CLK_MHZ*SETTLE_US` clock cycles. The defaults give 400 µs. Only then does it release soft-mute and reselect the DAC.

Top module: `codec_pwr_seq`

## Requirements
- R1: After reset, `pwr_state_o` is 0 (active), `busy_o` is 0, `req_ready_o` is 1 and `cmd_valid_o` is 0. The shadow copies reset to power 0x000, digital path 0x000 and analog path 0x012.
- R2: A request is taken when `req_valid_i` and `req_ready_o` are both high. Request codes are 0 active, 1 standby, 2 power-down and 3 noise recovery. `busy_o` is high from the next cycle until the series ends. While busy, `req_ready_o` is low and requests cause no writes.
- R3: While `cmd_valid_o` is high and `cmd_ready_i` is low, `cmd_valid_o`, `cmd_addr_o` and `cmd_data_o` hold their values.
- R4: Standby writes three registers in this order. First 0x05 with bit 3 set. Then 0x04 with bit 4 cleared. Then 0x06 with bits 0, 3 and 4 set and bit 7 clear. Bits 5 and 6 of 0x06 are set too, but only when `osc_is_sysclk_i` was low at acceptance.
- R5: Power-down writes 0x05 with bit 3 set, then 0x04 with bit 4 cleared. It then writes 0x06 with its previous value OR 0x080.
- R6: Return to active first writes 0x06 = 0x000. After the settling time it writes 0x05 with bit 3 cleared, then 0x04 with bit 4 set.
- R7: Noise recovery writes, in order: mute, deselect, 0x06 = previous OR 0x080, 0x06 = 0x000, settling wait, unmute, select. The block ends in the active state.
- R8: At least `CLK_MHZ*SETTLE_US` cycles lie between the write of 0x06 = 0x000 and the unmute write. `busy_o` stays high throughout.
- R9: `pwr_state_o` changes only when a series ends. It reads 0 after active or noise recovery, 1 after standby, and 2 after power-down.
- R10: Power bits 3 or 4 are never switched on while soft-mute is clear. Bit 3 is never switched on while the DAC is still selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Power request present |
| req_kind_i | input | 2 | Request code: 0 active, 1 standby, 2 power-down, 3 noise recovery |
| osc_is_sysclk_i | input | 1 | On-chip oscillator and clock output feed the system clock |
| req_ready_o | output | 1 | Block can take a request |
| cmd_valid_o | output | 1 | Register write offered |
| cmd_ready_i | input | 1 | Bus writer takes the write |
| cmd_addr_o | output | 7 | Codec register address |
| cmd_data_o | output | 9 | Codec register value |
| pwr_state_o | output | 2 | 0 active, 1 standby, 2 powered down |
| busy_o | output | 1 | A series is in progress |

## Verification
The bench chains standby, power-down, active and noise-recovery requests so that the shadow copies carry state from one series to the next. A design that rebuilt writes from constants would clobber bits 1 of 0x04 or lose the standby bits when powering down. It stretches `cmd_ready_i` into long stalls, which catches payload changes under back-pressure. It times the gap before unmute, which a short or skipped settle counter fails. It tries both oscillator settings and injects requests while busy; an unguarded acceptance would show up as an unexpected write.

// File: rtl/codec_pwr_pkg.sv
package codec_pwr_pkg;

  localparam int ADDR_W = 7;
  localparam int DATA_W = 9;
  localparam int IDX_W  = 3;

  localparam logic [ADDR_W-1:0] ADDR_APATH = 7'h04;
  localparam logic [ADDR_W-1:0] ADDR_DPATH = 7'h05;
  localparam logic [ADDR_W-1:0] ADDR_PWR   = 7'h06;

  localparam logic [DATA_W-1:0] APATH_DAC_SEL = 9'h010;
  localparam logic [DATA_W-1:0] DPATH_MUTE    = 9'h008;
  localparam logic [DATA_W-1:0] PD_LINE       = 9'h001;
  localparam logic [DATA_W-1:0] PD_DAC        = 9'h008;
  localparam logic [DATA_W-1:0] PD_OUT        = 9'h010;
  localparam logic [DATA_W-1:0] PD_OSC        = 9'h020;
  localparam logic [DATA_W-1:0] PD_CLKO       = 9'h040;
  localparam logic [DATA_W-1:0] PD_DEV        = 9'h080;

  typedef enum logic [1:0] {
    REQ_ACTIVE  = 2'd0,
    REQ_STANDBY = 2'd1,
    REQ_OFF     = 2'd2,
    REQ_NOISE   = 2'd3
  } req_e;

  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'd0,
    ST_STANDBY = 2'd1,
    ST_OFF     = 2'd2
  } pstate_e;

  typedef enum logic [2:0] {
    OP_MUTE,
    OP_DESEL,
    OP_PWR_DEV_OFF,
    OP_PWR_TGT,
    OP_SETTLE,
    OP_UNMUTE,
    OP_SEL,
    OP_END
  } op_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_STEP,
    S_SEND,
    S_WAIT
  } fsm_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cmd_t;

endpackage

// File: rtl/codec_pwr_prog.sv
module codec_pwr_prog
  import codec_pwr_pkg::*;
(
  input  req_e             kind_i,
  input  logic [IDX_W-1:0] idx_i,
  output op_e              op_o
);

  always_comb begin
    op_o = OP_END;
    unique case (kind_i)
      REQ_ACTIVE: begin
        unique case (idx_i)
          3'd0:    op_o = OP_PWR_TGT;
          3'd1:    op_o = OP_SETTLE;
          3'd2:    op_o = OP_UNMUTE;
          3'd3:    op_o = OP_SEL;
          default: op_o = OP_END;
        endcase
      end
      REQ_STANDBY: begin
        unique case (idx_i)
          3'd0:    op_o = OP_MUTE;
          3'd1:    op_o = OP_DESEL;
          3'd2:    op_o = OP_PWR_TGT;
          default: op_o = OP_END;
        endcase
      end
      REQ_OFF: begin
        unique case (idx_i)
          3'd0:    op_o = OP_MUTE;
          3'd1:    op_o = OP_DESEL;
          3'd2:    op_o = OP_PWR_DEV_OFF;
          default: op_o = OP_END;
        endcase
      end
      REQ_NOISE: begin
        unique case (idx_i)
          3'd0:    op_o = OP_MUTE;
          3'd1:    op_o = OP_DESEL;
          3'd2:    op_o = OP_PWR_DEV_OFF;
          3'd3:    op_o = OP_PWR_TGT;
          3'd4:    op_o = OP_SETTLE;
          3'd5:    op_o = OP_UNMUTE;
          3'd6:    op_o = OP_SEL;
          default: op_o = OP_END;
        endcase
      end
      default: op_o = OP_END;
    endcase
  end

endmodule

// File: rtl/codec_pwr_shadow.sv
module codec_pwr_shadow
  import codec_pwr_pkg::*;
#(
  parameter logic [DATA_W-1:0] DPATH_RST = 9'h000,
  parameter logic [DATA_W-1:0] APATH_RST = 9'h012
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  cmd_t              wr_cmd_i,
  output logic [DATA_W-1:0] pwr_o,
  output logic [DATA_W-1:0] dpath_o,
  output logic [DATA_W-1:0] apath_o
);

  logic [DATA_W-1:0] pwr_q, dpath_q, apath_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_q   <= '0;
      dpath_q <= DPATH_RST;
      apath_q <= APATH_RST;
    end else if (wr_en_i) begin
      unique case (wr_cmd_i.addr)
        ADDR_PWR:   pwr_q   <= wr_cmd_i.data;
        ADDR_DPATH: dpath_q <= wr_cmd_i.data;
        ADDR_APATH: apath_q <= wr_cmd_i.data;
        default: ;
      endcase
    end
  end

  assign pwr_o   = pwr_q;
  assign dpath_o = dpath_q;
  assign apath_o = apath_q;

  // R10
  dac_off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_q[3]) |-> (dpath_q[3] && !apath_q[4]));

  // R10
  out_off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_q[4]) |-> dpath_q[3]);

endmodule

// File: rtl/codec_pwr_settle.sv
module codec_pwr_settle #(
  parameter int CYC = 80000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic done_o
);

  localparam int CYC_EFF = (CYC < 1) ? 1 : CYC;
  localparam int CNT_W   = $clog2(CYC_EFF + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= CNT_W'(CYC_EFF - 1);
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = run_q && (cnt_q == '0);

endmodule

// File: rtl/codec_pwr_seq.sv
module codec_pwr_seq
  import codec_pwr_pkg::*;
#(
  parameter int                CLK_MHZ   = 200,
  parameter int                SETTLE_US = 400,
  parameter logic [DATA_W-1:0] DPATH_RST = 9'h000,
  parameter logic [DATA_W-1:0] APATH_RST = 9'h012
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_kind_i,
  input  logic              osc_is_sysclk_i,
  output logic              req_ready_o,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [DATA_W-1:0] cmd_data_o,
  output logic [1:0]        pwr_state_o,
  output logic              busy_o
);

  localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;

  fsm_e              fsm_q;
  req_e              kind_q;
  logic              osc_q;
  logic [IDX_W-1:0]  idx_q;
  op_e               op;
  cmd_t              cmd_q, next_cmd;
  logic              valid_q;
  pstate_e           state_q;
  logic [DATA_W-1:0] pwr_w, dpath_w, apath_w, tgt_pwr;
  logic              accept, hs, settle_start, settle_done;

  codec_pwr_prog i_prog (
    .kind_i (kind_q),
    .idx_i  (idx_q),
    .op_o   (op)
  );

  assign hs = valid_q && cmd_ready_i;

  codec_pwr_shadow #(
    .DPATH_RST (DPATH_RST),
    .APATH_RST (APATH_RST)
  ) i_shadow (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (hs),
    .wr_cmd_i (cmd_q),
    .pwr_o    (pwr_w),
    .dpath_o  (dpath_w),
    .apath_o  (apath_w)
  );

  assign settle_start = (fsm_q == S_STEP) && (op == OP_SETTLE);

  codec_pwr_settle #(
    .CYC (SETTLE_CYC)
  ) i_settle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (settle_start),
    .done_o  (settle_done)
  );

  always_comb begin
    tgt_pwr = '0;
    if (kind_q == REQ_STANDBY)
      tgt_pwr = PD_LINE | PD_DAC | PD_OUT | (osc_q ? '0 : (PD_OSC | PD_CLKO));
  end

  always_comb begin
    next_cmd = '{addr: ADDR_PWR, data: tgt_pwr};
    unique case (op)
      OP_MUTE:        next_cmd = '{addr: ADDR_DPATH, data: dpath_w | DPATH_MUTE};
      OP_DESEL:       next_cmd = '{addr: ADDR_APATH, data: apath_w & ~APATH_DAC_SEL};
      OP_PWR_DEV_OFF: next_cmd = '{addr: ADDR_PWR,   data: pwr_w | PD_DEV};
      OP_UNMUTE:      next_cmd = '{addr: ADDR_DPATH, data: dpath_w & ~DPATH_MUTE};
      OP_SEL:         next_cmd = '{addr: ADDR_APATH, data: apath_w | APATH_DAC_SEL};
      default:        next_cmd = '{addr: ADDR_PWR,   data: tgt_pwr};
    endcase
  end

  assign accept = req_valid_i && (fsm_q == S_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsm_q   <= S_IDLE;
      kind_q  <= REQ_ACTIVE;
      osc_q   <= 1'b0;
      idx_q   <= '0;
      cmd_q   <= '0;
      valid_q <= 1'b0;
      state_q <= ST_ACTIVE;
    end else begin
      unique case (fsm_q)
        S_IDLE: if (accept) begin
          kind_q <= req_e'(req_kind_i);
          osc_q  <= osc_is_sysclk_i;
          idx_q  <= '0;
          fsm_q  <= S_STEP;
        end
        S_STEP: begin
          unique case (op)
            OP_SETTLE: fsm_q <= S_WAIT;
            OP_END: begin
              unique case (kind_q)
                REQ_STANDBY: state_q <= ST_STANDBY;
                REQ_OFF:     state_q <= ST_OFF;
                default:     state_q <= ST_ACTIVE;
              endcase
              fsm_q <= S_IDLE;
            end
            default: begin
              cmd_q   <= next_cmd;
              valid_q <= 1'b1;
              fsm_q   <= S_SEND;
            end
          endcase
        end
        S_SEND: if (cmd_ready_i) begin
          valid_q <= 1'b0;
          idx_q   <= idx_q + 1'b1;
          fsm_q   <= S_STEP;
        end
        S_WAIT: if (settle_done) begin
          idx_q <= idx_q + 1'b1;
          fsm_q <= S_STEP;
        end
        default: fsm_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o = (fsm_q == S_IDLE);
  assign busy_o      = (fsm_q != S_IDLE);
  assign cmd_valid_o = valid_q;
  assign cmd_addr_o  = cmd_q.addr;
  assign cmd_data_o  = cmd_q.data;
  assign pwr_state_o = state_q;

  // R2
  take_sets_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> busy_o);

  // R3
  cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ready_i) |=>
      (cmd_valid_o && $stable(cmd_addr_o) && $stable(cmd_data_o)));

  // R6
  unmute_powered_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_addr_o == ADDR_DPATH && !cmd_data_o[3]) |-> !pwr_w[7]);

  // R9
  active_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && pwr_state_o == 2'd0) |-> (pwr_w == '0));

endmodule

// File: tb/test_codec_pwr_seq.sv
module test_codec_pwr_seq;

  localparam int CLK_MHZ    = 200;
  localparam int SETTLE_US  = 1;
  localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_valid_i = 1'b0;
  logic [1:0] req_kind_i = 2'd0;
  logic       osc_is_sysclk_i = 1'b1;
  logic       req_ready_o;
  logic       cmd_valid_o;
  logic       cmd_ready_i = 1'b0;
  logic [6:0] cmd_addr_o;
  logic [8:0] cmd_data_o;
  logic [1:0] pwr_state_o;
  logic       busy_o;

  codec_pwr_seq #(
    .CLK_MHZ   (CLK_MHZ),
    .SETTLE_US (SETTLE_US)
  ) i_codec_pwr_seq (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .req_valid_i     (req_valid_i),
    .req_kind_i      (req_kind_i),
    .osc_is_sysclk_i (osc_is_sysclk_i),
    .req_ready_o     (req_ready_o),
    .cmd_valid_o     (cmd_valid_o),
    .cmd_ready_i     (cmd_ready_i),
    .cmd_addr_o      (cmd_addr_o),
    .cmd_data_o      (cmd_data_o),
    .pwr_state_o     (pwr_state_o),
    .busy_o          (busy_o)
  );

  always #2.5 clk_i = ~clk_i;

  int    checks = 0;
  int    failures = 0;
  int    cyc = 0;
  int    rdy_mode = 0;
  bit    done = 0;
  int    sh_pwr = 0, sh_dp = 0, sh_ap = 'h012, exp_state = 0;
  int    exp_a[$], exp_d[$];
  bit    exp_gap[$];
  string exp_tag[$];
  int    last_hs = 0;
  bit    prev_v = 0, prev_hs = 0;
  int    prev_a = 0, prev_d = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic push(input int a, input int d, input bit gap, input string tag);
    exp_a.push_back(a); exp_d.push_back(d); exp_gap.push_back(gap); exp_tag.push_back(tag);
  endtask

  task automatic plan(input int kind, input bit osc);
    string t;
    t = (kind == 0) ? "R6" : (kind == 1) ? "R4" : (kind == 2) ? "R5" : "R7";
    if (kind != 0) begin
      sh_dp = sh_dp | 'h008;  push(5, sh_dp, 0, t);
      sh_ap = sh_ap & ~'h010; push(4, sh_ap, 0, t);
    end
    if (kind == 1) begin
      sh_pwr = 'h019 | (osc ? 0 : 'h060); push(6, sh_pwr, 0, t);
      exp_state = 1;
    end else if (kind == 2) begin
      sh_pwr = sh_pwr | 'h080; push(6, sh_pwr, 0, t);
      exp_state = 2;
    end else begin
      if (kind == 3) begin sh_pwr = sh_pwr | 'h080; push(6, sh_pwr, 0, t); end
      sh_pwr = 0; push(6, 0, 0, t);
      sh_dp = sh_dp & ~'h008; push(5, sh_dp, 1, t);
      sh_ap = sh_ap | 'h010;  push(4, sh_ap, 0, t);
      exp_state = 0;
    end
  endtask

  // Drives ready and compares every clock
  always @(negedge clk_i) begin
    bit r;
    case (rdy_mode)
      0:       r = 1'b1;
      1:       r = (cyc % 3) != 0;
      default: r = (cyc % 7) == 6;
    endcase
    cmd_ready_i = r;
    if (rst_ni) begin
      chk(req_ready_o == !busy_o, "R2 ready vs busy", req_ready_o, !busy_o);
      if (prev_v && !prev_hs)
        chk(cmd_valid_o && cmd_addr_o == prev_a && cmd_data_o == prev_d,
            "R3 hold", {cmd_valid_o, cmd_addr_o, cmd_data_o}, {1'b1, prev_a[6:0], prev_d[8:0]});
      if (!busy_o)
        chk(pwr_state_o == exp_state || exp_a.size() != 0, "R9 state", pwr_state_o, exp_state);
      if (cmd_valid_o && r) begin
        if (exp_a.size() == 0) begin
          chk(0, "R2 unexpected write", {cmd_addr_o, cmd_data_o}, 0);
        end else begin
          string t;
          t = exp_tag.pop_front();
          chk(cmd_addr_o == exp_a[0] && cmd_data_o == exp_d[0], t,
              {cmd_addr_o, cmd_data_o}, {exp_a[0][6:0], exp_d[0][8:0]});
          if (exp_gap[0])
            chk(cyc - last_hs >= SETTLE_CYC, "R8 settle gap", cyc - last_hs, SETTLE_CYC);
          void'(exp_a.pop_front()); void'(exp_d.pop_front()); void'(exp_gap.pop_front());
        end
        last_hs = cyc;
      end
    end
    prev_v = cmd_valid_o; prev_hs = cmd_valid_o && r;
    prev_a = cmd_addr_o;  prev_d = cmd_data_o;
  end

  task automatic start_req(input int kind, input bit osc);
    @(negedge clk_i);
    plan(kind, osc);
    req_valid_i = 1'b1; req_kind_i = kind[1:0]; osc_is_sysclk_i = osc;
    @(negedge clk_i);
    chk(busy_o == 1'b1, "R2 accept", busy_o, 1);
    req_valid_i = 1'b0;
  endtask

  task automatic finish_req(input int kind);
    while (busy_o) @(negedge clk_i);
    chk(exp_a.size() == 0, "R2 writes left", exp_a.size(), 0);
    chk(pwr_state_o == exp_state, (kind == 3) ? "R7 end state" : "R9 end state",
        pwr_state_o, exp_state);
  endtask

  task automatic run(input int kind, input bit osc);
    start_req(kind, osc);
    finish_req(kind);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(pwr_state_o == 0 && !busy_o && req_ready_o && !cmd_valid_o, "R1 in reset",
        {pwr_state_o, busy_o, req_ready_o, cmd_valid_o}, 'b0010);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(pwr_state_o == 0 && !busy_o && req_ready_o && !cmd_valid_o, "R1 after reset",
        {pwr_state_o, busy_o, req_ready_o, cmd_valid_o}, 'b0010);

    rdy_mode = 0; run(1, 1'b1);   // R4 oscillator is clock source
    rdy_mode = 1; run(0, 1'b1);   // R6
    rdy_mode = 2; run(1, 1'b0);   // R4 oscillator bits set
    rdy_mode = 1; run(2, 1'b0);   // R5 keeps standby bits
    rdy_mode = 0; run(0, 1'b0);   // R6 from power-down
    rdy_mode = 2;
    start_req(2, 1'b0);           // R5 from active
    req_valid_i = 1'b1; req_kind_i = 2'd0;
    repeat (5) begin
      @(negedge clk_i);
      chk(req_ready_o == 1'b0, "R2 refuse while busy", req_ready_o, 0);
    end
    req_valid_i = 1'b0;
    finish_req(2);
    rdy_mode = 1; run(3, 1'b1);   // R7 from power-down
    rdy_mode = 0; run(3, 1'b1);   // R7 from active
    repeat (4) @(negedge clk_i);
    chk(!cmd_valid_o && exp_a.size() == 0, "R2 idle quiet", cmd_valid_o, 0);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule